// File: doc/BRIEF.md
# Packed Saturating Doubling Multiply-High Unit

This block multiplies two packed vectors of signed integers lane by lane. Each product is doubled and then reduced to its upper half, so the block works as a fixed-point fractional multiplier. Before the shift it can add half of the result's least significant bit, which rounds the result. The only product that can fall outside the signed lane range is the square of the most negative value. That lane is clamped to the largest positive value. A sticky flag records every clamp and holds until it is cleared.

A lane-size code selects 16-bit or 32-bit lanes. In vector mode, a width select picks 64 or 128 active data bits. In scalar mode only lane 0 is computed. Results appear one clock after the request. The two unused size codes are rejected: they raise an illegal-encoding pulse and produce no result.

Top module: `dbl_mulhi_unit`

## Requirements
- R1: The 2-bit size code sets the lane width to 8 << code. Code 1 gives 16-bit lanes and code 2 gives 32-bit lanes. A valid request with code 0 or 3 drives `illegal` high in the next cycle, keeps `out_vld` low, returns an all-zero result and `lane_sat`, and leaves `sat_sticky` unchanged unless `flag_clr` is high.
- R2: For each active lane, with `a` and `b` the sign-extended lane values of `opa` and `opb`, the lane result is (2*a*b + bias) arithmetically shifted right by the lane width, then saturated to the signed lane range. Lane i occupies bits [i*w +: w].
- R3: When `round_en` is 1, bias = 2^(w-1). When `round_en` is 0, bias = 0 and the result is the truncated shift.
- R4: A lane saturates only when both of its inputs equal the most negative value. Such a lane returns the most positive value in both forms, and `lane_sat[i]` is set for lane i. All other `lane_sat` bits are 0.
- R5: `sat_sticky` becomes 1 in the cycle a saturating result is output. It stays 1 until a cycle with `flag_clr` high clears it. If a clear and a new saturation arrive together, the flag ends up set.
- R6: In vector mode (`scalar_sel`=0), `full_sel`=1 computes 128/w lanes. `full_sel`=0 computes 64/w lanes and drives result bits [127:64] to zero.
- R7: In scalar mode (`scalar_sel`=1), only lane 0 is computed, whatever the value of `full_sel`. All result bits above lane 0 and all `lane_sat` bits above bit 0 are zero.
- R8: `out_vld` is `in_vld` of a legal request delayed by one clock. In a cycle after no valid request, `out_vld`, `illegal`, `result` and `lane_sat` are zero.
- R9: Synchronous active-high `rst` clears all outputs and `sat_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| opa | input | 128 | First packed operand |
| opb | input | 128 | Second packed operand |
| size_code | input | 2 | Lane size code (1 = 16-bit, 2 = 32-bit, others illegal) |
| full_sel | input | 1 | Vector width: 1 = 128 bits, 0 = 64 bits |
| scalar_sel | input | 1 | 1 = compute lane 0 only |
| round_en | input | 1 | 1 = rounding form, 0 = truncating form |
| flag_clr | input | 1 | Clears the sticky saturation flag |
| out_vld | output | 1 | Result strobe, one cycle after a legal request |
| result | output | 128 | Packed lane results |
| lane_sat | output | 8 | Per-lane saturation bits, bit i for lane i |
| sat_sticky | output | 1 | Cumulative saturation flag |
| illegal | output | 1 | Illegal size code seen on the previous request |

## Verification
The bench aims at the square of the most negative value in both lane widths and in both rounding forms. A design that drops the clamp returns the most negative value with no saturation bit. Rounding is probed at the exact half-LSB boundary, where a missing or misplaced bias gives a result that is off by one. Half-width and scalar requests use non-zero upper operand bits, so a design that leaks stale lanes shows non-zero upper bits. The bench also issues a clear in the same cycle as a clamp, which exposes a flag that lets the clear win. Finally, illegal codes are sent with operands that would saturate, so a design that still computes them sets the sticky flag by mistake.

// File: rtl/dbl_mulhi_pkg.sv
package dbl_mulhi_pkg;

   typedef enum logic [1:0] {
      LSZ_8  = 2'd0,
      LSZ_16 = 2'd1,
      LSZ_32 = 2'd2,
      LSZ_64 = 2'd3
   } lane_sz_e;

   localparam int unsigned NARROW_W = 16;
   localparam int unsigned WIDE_W   = 32;
   localparam int unsigned HALF_DW  = 64;

   function automatic logic size_is_legal(input logic [1:0] code);
      return (code == LSZ_16) || (code == LSZ_32);
   endfunction

endpackage

// File: rtl/dmh_lane.sv
// One lane: doubled signed product, optional half-LSB bias, high half, clamp.
module dmh_lane #(
   parameter int unsigned EW = 16
) (
   input  logic [EW-1:0] a,
   input  logic [EW-1:0] b,
   input  logic          rnd,
   output logic [EW-1:0] y,
   output logic          sat
);
   localparam int unsigned PW = 2*EW + 2;
   localparam int unsigned SW = PW - EW;

   if (EW < 4) begin : g_bad_ew
      $error("dmh_lane: EW must be at least 4");
   end

   logic signed [PW-1:0] ax, bx, prod, biased;
   logic signed [SW-1:0] shifted;
   logic [SW-EW:0]       guard;

   always_comb begin
      ax      = {{(PW-EW){a[EW-1]}}, a};
      bx      = {{(PW-EW){b[EW-1]}}, b};
      prod    = (ax * bx) <<< 1;
      biased  = prod + (rnd ? (PW'(1) << (EW-1)) : '0);
      shifted = biased[PW-1:EW];
      guard   = shifted[SW-1:EW-1];
      sat     = !((&guard) || !(|guard));
      if (sat)
         y = shifted[SW-1] ? {1'b1, {(EW-1){1'b0}}} : {1'b0, {(EW-1){1'b1}}};
      else
         y = shifted[EW-1:0];
   end
endmodule

// File: rtl/dmh_lane_mask.sv
// Decides which lanes of each width are active for the request shape.
module dmh_lane_mask #(
   parameter int unsigned DATA_W = 128
) (
   input  logic                 full_sel,
   input  logic                 scalar_sel,
   output logic [DATA_W/16-1:0] act16,
   output logic [DATA_W/32-1:0] act32
);
   localparam int unsigned N16 = DATA_W / dbl_mulhi_pkg::NARROW_W;
   localparam int unsigned N32 = DATA_W / dbl_mulhi_pkg::WIDE_W;
   localparam int unsigned H16 = dbl_mulhi_pkg::HALF_DW / dbl_mulhi_pkg::NARROW_W;
   localparam int unsigned H32 = dbl_mulhi_pkg::HALF_DW / dbl_mulhi_pkg::WIDE_W;

   for (genvar i = 0; i < N16; i++) begin : g_m16
      if (i == 0) begin : g_first
         assign act16[i] = 1'b1;
      end else if (i < H16) begin : g_low
         assign act16[i] = !scalar_sel;
      end else begin : g_high
         assign act16[i] = !scalar_sel && full_sel;
      end
   end

   for (genvar j = 0; j < N32; j++) begin : g_m32
      if (j == 0) begin : g_first
         assign act32[j] = 1'b1;
      end else if (j < H32) begin : g_low
         assign act32[j] = !scalar_sel;
      end else begin : g_high
         assign act32[j] = !scalar_sel && full_sel;
      end
   end
endmodule

// File: rtl/dmh_sticky.sv
// Cumulative saturation flag; a new set wins over a simultaneous clear.
module dmh_sticky (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic set,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (rst) flag <= 1'b0;
      else     flag <= (flag && !clr) || set;
   end

   p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      set |=> flag);
   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/dbl_mulhi_unit.sv
module dbl_mulhi_unit #(
   parameter int unsigned DATA_W = 128
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_vld,
   input  logic [DATA_W-1:0]    opa,
   input  logic [DATA_W-1:0]    opb,
   input  logic [1:0]           size_code,
   input  logic                 full_sel,
   input  logic                 scalar_sel,
   input  logic                 round_en,
   input  logic                 flag_clr,
   output logic                 out_vld,
   output logic [DATA_W-1:0]    result,
   output logic [DATA_W/16-1:0] lane_sat,
   output logic                 sat_sticky,
   output logic                 illegal
);
   import dbl_mulhi_pkg::*;

   localparam int unsigned N16 = DATA_W / NARROW_W;
   localparam int unsigned N32 = DATA_W / WIDE_W;
   localparam int unsigned H16 = HALF_DW / NARROW_W;

   if (DATA_W != 2*HALF_DW) begin : g_bad_dw
      $error("dbl_mulhi_unit: DATA_W must be twice the half width");
   end

   logic                legal, go;
   logic [N16-1:0]      act16, sat16_raw, sat16;
   logic [N32-1:0]      act32, sat32_raw, sat32;
   logic [DATA_W-1:0]   res16, res32, res_n;
   logic [N16-1:0]      sat_n;

   dmh_lane_mask #(.DATA_W(DATA_W)) u_mask (
      .full_sel  (full_sel),
      .scalar_sel(scalar_sel),
      .act16     (act16),
      .act32     (act32)
   );

   for (genvar i = 0; i < N16; i++) begin : g_l16
      logic [NARROW_W-1:0] y;
      dmh_lane #(.EW(NARROW_W)) u_lane (
         .a  (opa[i*NARROW_W +: NARROW_W]),
         .b  (opb[i*NARROW_W +: NARROW_W]),
         .rnd(round_en),
         .y  (y),
         .sat(sat16_raw[i])
      );
      assign res16[i*NARROW_W +: NARROW_W] = act16[i] ? y : '0;
      assign sat16[i] = act16[i] && sat16_raw[i];
   end

   for (genvar j = 0; j < N32; j++) begin : g_l32
      logic [WIDE_W-1:0] y;
      dmh_lane #(.EW(WIDE_W)) u_lane (
         .a  (opa[j*WIDE_W +: WIDE_W]),
         .b  (opb[j*WIDE_W +: WIDE_W]),
         .rnd(round_en),
         .y  (y),
         .sat(sat32_raw[j])
      );
      assign res32[j*WIDE_W +: WIDE_W] = act32[j] ? y : '0;
      assign sat32[j] = act32[j] && sat32_raw[j];
   end

   always_comb begin
      legal = size_is_legal(size_code);
      go    = in_vld && legal;
      res_n = '0;
      sat_n = '0;
      if (go) begin
         if (size_code == LSZ_16) begin
            res_n = res16;
            sat_n = sat16;
         end else begin
            res_n = res32;
            sat_n = N16'(sat32);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         illegal  <= 1'b0;
         result   <= '0;
         lane_sat <= '0;
      end else begin
         out_vld  <= go;
         illegal  <= in_vld && !legal;
         result   <= res_n;
         lane_sat <= sat_n;
      end
   end

   dmh_sticky u_sticky (
      .clk (clk),
      .rst (rst),
      .clr (flag_clr),
      .set (|sat_n),
      .flag(sat_sticky)
   );

   p_illegal_r1: assert property (@(posedge clk) disable iff (rst)
      (in_vld && !(size_code == 2'd1 || size_code == 2'd2))
      |=> (illegal && !out_vld && result == '0 && lane_sat == '0));
   p_vld_r8: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (size_code == 2'd1 || size_code == 2'd2)) |=> out_vld);
   p_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> (!out_vld && !illegal && result == '0 && lane_sat == '0));
   p_sat_max_r4: assert property (@(posedge clk) disable iff (rst)
      (out_vld && lane_sat[0] && $past(size_code) == 2'd1)
      |-> (result[15:0] == 16'h7fff));
   p_sticky_set_r5: assert property (@(posedge clk) disable iff (rst)
      (out_vld && |lane_sat) |-> sat_sticky);
   p_half_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(!full_sel)) |-> (result[DATA_W-1:HALF_DW] == '0));
   p_scalar_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(scalar_sel))
      |-> (result[DATA_W-1:WIDE_W] == '0 && lane_sat[N16-1:1] == '0));
   p_reset_r9: assert property (@(posedge clk)
      rst |=> (!out_vld && !sat_sticky && !illegal && result == '0));
   p_half_sat_r6: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(!full_sel)) |-> (lane_sat[N16-1:H16] == '0));
endmodule

// File: tb/test_dbl_mulhi_unit.sv
module test_dbl_mulhi_unit;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_vld = 1'b0;
   logic [127:0] opa = '0, opb = '0;
   logic [1:0]   size_code = 2'd1;
   logic         full_sel = 1'b0, scalar_sel = 1'b0, round_en = 1'b0, flag_clr = 1'b0;
   logic         out_vld, sat_sticky, illegal;
   logic [127:0] result;
   logic [7:0]   lane_sat;

   int total = 0;
   int bad   = 0;
   logic exp_st = 1'b0;

   always #2 clk = ~clk;

   dbl_mulhi_unit i_dbl_mulhi_unit (
      .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
      .size_code(size_code), .full_sel(full_sel), .scalar_sel(scalar_sel),
      .round_en(round_en), .flag_clr(flag_clr), .out_vld(out_vld),
      .result(result), .lane_sat(lane_sat), .sat_sticky(sat_sticky),
      .illegal(illegal)
   );

   task automatic chk(input logic ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                 input logic [1:0] sz, input logic full,
                                 input logic scal, input logic rnd,
                                 output logic [127:0] r, output logic [7:0] s);
      int ew, dw, n;
      r = '0;
      s = '0;
      if (sz == 2'd1 || sz == 2'd2) begin
         ew = (sz == 2'd1) ? 16 : 32;
         dw = scal ? ew : (full ? 128 : 64);
         n  = dw / ew;
         for (int i = 0; i < n; i++) begin
            logic signed [66:0] x, y, p, mx;
            if (ew == 16) begin
               x = 67'(signed'(a[i*16 +: 16]));
               y = 67'(signed'(b[i*16 +: 16]));
            end else begin
               x = 67'(signed'(a[i*32 +: 32]));
               y = 67'(signed'(b[i*32 +: 32]));
            end
            p = 67'sd2 * x * y;
            if (rnd) p = p + (67'sd1 <<< (ew - 1));
            p  = p >>> ew;
            mx = (67'sd1 <<< (ew - 1)) - 67'sd1;
            if (p > mx) begin
               p = mx;
               s[i] = 1'b1;
            end else if (p < -mx - 67'sd1) begin
               p = -mx - 67'sd1;
               s[i] = 1'b1;
            end
            if (ew == 16) r[i*16 +: 16] = p[15:0];
            else          r[i*32 +: 32] = p[31:0];
         end
      end
   endfunction

   // Issue one request, then check all outputs one cycle later.
   task automatic op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                     input logic full, input logic scal, input logic rnd,
                     input logic clr, input string req);
      logic [127:0] er;
      logic [7:0]   es;
      logic         lg;
      @(negedge clk);
      in_vld = 1'b1; opa = a; opb = b; size_code = sz; full_sel = full;
      scalar_sel = scal; round_en = rnd; flag_clr = clr;
      model(a, b, sz, full, scal, rnd, er, es);
      lg = (sz == 2'd1 || sz == 2'd2);
      exp_st = (clr ? 1'b0 : exp_st) | (lg && |es);
      @(negedge clk);
      in_vld = 1'b0; flag_clr = 1'b0;
      chk(out_vld == lg, {req, " R8 out_vld"}, 128'(out_vld), 128'(lg));
      chk(illegal == !lg, {req, " R1 illegal"}, 128'(illegal), 128'(!lg));
      chk(result == er, {req, " R2 result"}, result, er);
      chk(lane_sat == es, {req, " R4 lane_sat"}, 128'(lane_sat), 128'(es));
      chk(sat_sticky == exp_st, {req, " R5 sticky"}, 128'(sat_sticky), 128'(exp_st));
   endtask

   localparam logic [127:0] MIN16 = {8{16'h8000}};
   localparam logic [127:0] MIN32 = {4{32'h8000_0000}};

   initial begin
      repeat (3) @(negedge clk);
      chk(out_vld == 1'b0 && result == '0 && lane_sat == '0 && sat_sticky == 1'b0
          && illegal == 1'b0, "R9 reset state", result, '0);
      rst = 1'b0;

      // R3 rounding boundary: 2*1*0x4000 = 0x8000 -> 0 truncated, 1 rounded
      op({8{16'h0001}}, {8{16'h4000}}, 2'd1, 1, 0, 0, 0, "R3 trunc16");
      op({8{16'h0001}}, {8{16'h4000}}, 2'd1, 1, 0, 1, 0, "R3 round16");
      op({4{32'h0000_0001}}, {4{32'h4000_0000}}, 2'd2, 1, 0, 1, 0, "R3 round32");
      op({4{32'hffff_ffff}}, {4{32'h4000_0000}}, 2'd2, 1, 0, 0, 0, "R3 trunc32neg");
      // R4 most-negative squared in both widths and forms
      op(MIN16, MIN16, 2'd1, 1, 0, 0, 0, "R4 min16 trunc");
      op(MIN32, MIN32, 2'd2, 1, 0, 1, 0, "R4 min32 round");
      // R5 clear alone, then clear together with a new clamp
      op('0, '0, 2'd1, 1, 0, 0, 1, "R5 clear");
      op({112'd0, 16'h8000}, {112'd0, 16'h8000}, 2'd1, 1, 0, 1, 1, "R5 clear+sat");
      op('0, '0, 2'd2, 1, 0, 0, 0, "R5 hold");
      op('0, '0, 2'd1, 1, 0, 0, 1, "R5 clear2");
      // R6 half width with saturating upper lanes
      op(MIN16, MIN16, 2'd1, 0, 0, 0, 0, "R6 half16");
      op(MIN32, {4{32'h7fff_0000}}, 2'd2, 0, 0, 1, 1, "R6 half32");
      // R7 scalar, full_sel set and busy upper lanes
      op({8{16'h8000}}, {8{16'h8000}}, 2'd1, 1, 1, 0, 1, "R7 scalar16");
      op({4{32'h1234_5678}}, {4{32'h9abc_def0}}, 2'd2, 1, 1, 1, 1, "R7 scalar32");
      // R1 illegal codes with saturating operands
      op(MIN16, MIN16, 2'd0, 1, 0, 0, 1, "R1 code0");
      op(MIN32, MIN32, 2'd3, 1, 0, 1, 0, "R1 code3");
      // R8 idle cycle produces nothing
      @(negedge clk);
      chk(out_vld == 1'b0 && illegal == 1'b0 && result == '0,
          "R8 idle", result, '0);

      // R2 constrained random mix with corner values
      void'($urandom(32'd7));
      for (int k = 0; k < 400; k++) begin
         logic [127:0] a, b;
         logic [1:0]   sz;
         a = {$urandom, $urandom, $urandom, $urandom};
         b = {$urandom, $urandom, $urandom, $urandom};
         if ($urandom_range(0, 3) == 0) a = ($urandom_range(0, 1) != 0) ? MIN16 : MIN32;
         if ($urandom_range(0, 3) == 0) b = ($urandom_range(0, 1) != 0) ? MIN16 : MIN32;
         sz = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3))
                                          : 2'($urandom_range(1, 2));
         op(a, b, sz, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0), "R2 random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog R8 act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule